// File: doc/BRIEF.md
# Bit-Addressed Carry Logic Sequencer

This block is a multi-cycle execution unit inside an 8-bit CPU core. It runs the group of instructions that combine one bit of a data byte with the carry flag. Once started, it fetches two operand bytes from the instruction stream, low byte first, and joins them into a 16-bit word. The upper three bits of that word select a bit inside a byte. The lower thirteen bits give the byte address. The unit then reads the byte. Depending on a 3-bit operation code, it either computes a new carry from the selected bit or writes a changed copy of the byte back to the same address.

The unit issues exactly one bus request per clock: idle, fetch, read or write. Memory answers with read data in the same cycle that carries the request. Instruction decode, the program counter and the memory itself sit outside the block. The decoder pulses a start strobe together with the operation code and the current carry. The unit answers with a one-cycle done pulse and the updated carry.

Top module: `bitcarry_seq`

## Requirements
- R1: After an accepted start, the unit issues two fetch cycles, capturing the low byte and then the high byte, followed by one read cycle. The read address is word bits [12:0], and word bits [15:13] select the bit index.
- R2: The bus request encoding is 0 idle, 1 fetch, 2 read, 3 write. The request is idle whenever no operation is in progress.
- R3: Op 0 gives carry OR bit. Op 1 gives carry OR (NOT bit).
- R4: Op 2 gives carry AND bit. Op 3 gives carry AND (NOT bit).
- R5: Op 4 gives carry XOR bit. Op 5 loads carry from the bit.
- R6: Op 6 stores the carry into the selected bit. Op 7 inverts the selected bit. Each writes the byte back to the address it read, and never before that read.
- R7: Ops 0, 1, 4 and 6 insert one idle cycle directly after the read. Ops 2, 3, 5 and 7 insert none. Bus cycle totals are 3 for ops 2, 3 and 5; 4 for ops 0, 1, 4 and 7; and 5 for op 6.
- R8: The written byte equals the byte read, except for the selected bit.
- R9: Ops 0 to 5 issue no write. In the cycle after the last bus cycle, done is high for one cycle and the carry output shows the result. The carry input is sampled when start is accepted. The carry output changes only with done, and ops 6 and 7 return the sampled carry unchanged.
- R10: A start strobe that arrives while an operation is in progress is ignored. The operation code and the running sequence are not affected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin an operation (taken only when idle) |
| mode_i | input | 3 | Operation code, 0..7 |
| carry_i | input | 1 | Current carry flag |
| rdata_i | input | 8 | Read or fetch data, valid in the cycle of the request |
| bus_op_o | output | 2 | Bus request of this cycle |
| bus_addr_o | output | 13 | Target byte address during read and write, else 0 |
| wdata_o | output | 8 | Byte to write during a write cycle, else 0 |
| carry_o | output | 1 | Resulting carry flag |
| done_o | output | 1 | One-cycle pulse after the last bus cycle |

## Verification
The first fetch appears in the cycle after start is accepted. The read comes two cycles later. The optional idle and write follow at fixed offsets set by the operation code, and done and the new carry appear one cycle after the last bus request. The bench builds that exact per-cycle sequence of requests for each operation in a queue. It pops one entry per clock, samples outputs at the falling edge, and supplies operand and memory bytes only for the cycle that asks for them. This makes an extra, missing or reordered cycle show up as a mismatch at the cycle where it occurs. After each operation it also checks that done drops again and the bus returns to idle. A stray start pulse sent during a busy run must leave that queue unchanged.

// File: rtl/bcs_pkg.sv
package bcs_pkg;

  typedef enum logic [1:0] {
    BUS_IDLE  = 2'd0,
    BUS_FETCH = 2'd1,
    BUS_READ  = 2'd2,
    BUS_WRITE = 2'd3
  } bus_op_e;

  typedef enum logic [2:0] {
    M_OR   = 3'd0,
    M_ORN  = 3'd1,
    M_AND  = 3'd2,
    M_ANDN = 3'd3,
    M_XOR  = 3'd4,
    M_LD   = 3'd5,
    M_ST   = 3'd6,
    M_NOT  = 3'd7
  } bit_mode_e;

  typedef enum logic [2:0] {
    S_WAIT = 3'd0,
    S_FLO  = 3'd1,
    S_FHI  = 3'd2,
    S_RD   = 3'd3,
    S_GAP  = 3'd4,
    S_WR   = 3'd5
  } seq_st_e;

  function automatic logic mode_has_gap(bit_mode_e m);
    return (m == M_OR) || (m == M_ORN) || (m == M_XOR) || (m == M_ST);
  endfunction

  function automatic logic mode_writes(bit_mode_e m);
    return (m == M_ST) || (m == M_NOT);
  endfunction

endpackage

// File: rtl/bcs_ctrl.sv
module bcs_ctrl
  import bcs_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      start_i,
  input  logic [2:0] mode_i,
  output bit_mode_e mode_o,
  output seq_st_e   state_o,
  output bus_op_e   bus_op_o,
  output logic      accept_o,
  output logic      last_o,
  output logic      done_o
);

  seq_st_e   state_q, state_d;
  bit_mode_e mode_q;
  logic      gap, wr;

  assign gap = mode_has_gap(mode_q);
  assign wr  = mode_writes(mode_q);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_WAIT:  state_d = start_i ? S_FLO : S_WAIT;
      S_FLO:   state_d = S_FHI;
      S_FHI:   state_d = S_RD;
      S_RD:    state_d = gap ? S_GAP : (wr ? S_WR : S_WAIT);
      S_GAP:   state_d = wr ? S_WR : S_WAIT;
      S_WR:    state_d = S_WAIT;
      default: state_d = S_WAIT;
    endcase
  end

  assign accept_o = (state_q == S_WAIT) && start_i;
  assign last_o   = (state_q != S_WAIT) && (state_d == S_WAIT);

  always_comb begin
    unique case (state_q)
      S_FLO, S_FHI: bus_op_o = BUS_FETCH;
      S_RD:         bus_op_o = BUS_READ;
      S_WR:         bus_op_o = BUS_WRITE;
      default:      bus_op_o = BUS_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_WAIT;
      mode_q  <= M_OR;
      done_o  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_o  <= last_o;
      if (accept_o) mode_q <= bit_mode_e'(mode_i);
    end
  end

  assign mode_o  = mode_q;
  assign state_o = state_q;

  a_r1_read_after_fetch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_op_o == BUS_READ |-> $past(bus_op_o) == BUS_FETCH);

  a_r6_write_after_access: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_op_o == BUS_WRITE |-> ($past(bus_op_o) == BUS_READ || $past(bus_op_o) == BUS_IDLE));

  a_r9_write_only_store_modes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_op_o == BUS_WRITE |-> (mode_q == M_ST || mode_q == M_NOT));

  a_r10_busy_start_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != S_WAIT && start_i) |=> $stable(mode_q));

  a_r9_done_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r2_idle_when_waiting: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(bus_op_o) != BUS_FETCH);

endmodule

// File: rtl/bcs_operand.sv
module bcs_operand #(
  parameter  int DATA_W = 8,
  localparam int BIT_W  = $clog2(DATA_W),
  localparam int WORD_W = 2 * DATA_W,
  localparam int ADDR_W = WORD_W - BIT_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cap_lo_i,
  input  logic              cap_hi_i,
  input  logic              cap_data_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [BIT_W-1:0]  bit_o,
  output logic [DATA_W-1:0] data_o
);

  logic [WORD_W-1:0] word_q;
  logic [DATA_W-1:0] data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q <= '0;
      data_q <= '0;
    end else begin
      if (cap_lo_i)   word_q[DATA_W-1:0]      <= rdata_i;
      if (cap_hi_i)   word_q[WORD_W-1:DATA_W] <= rdata_i;
      if (cap_data_i) data_q                  <= rdata_i;
    end
  end

  // bit index rides in the top of the operand word
  assign bit_o  = word_q[WORD_W-1:ADDR_W];
  assign addr_o = word_q[ADDR_W-1:0];
  // the read cycle itself may be the last one, so forward live data
  assign data_o = cap_data_i ? rdata_i : data_q;

endmodule

// File: rtl/bcs_bitalu.sv
module bcs_bitalu
  import bcs_pkg::*;
#(
  parameter  int DATA_W = 8,
  localparam int BIT_W  = $clog2(DATA_W)
) (
  input  bit_mode_e         mode_i,
  input  logic [BIT_W-1:0]  bit_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              carry_i,
  output logic              carry_o,
  output logic [DATA_W-1:0] wbyte_o
);

  logic sel, new_bit;

  assign sel = data_i[bit_i];

  always_comb begin
    carry_o = carry_i;
    new_bit = sel;
    unique case (mode_i)
      M_OR:   carry_o = carry_i | sel;
      M_ORN:  carry_o = carry_i | ~sel;
      M_AND:  carry_o = carry_i & sel;
      M_ANDN: carry_o = carry_i & ~sel;
      M_XOR:  carry_o = carry_i ^ sel;
      M_LD:   carry_o = sel;
      M_ST:   new_bit = carry_i;
      M_NOT:  new_bit = ~sel;
      default: carry_o = carry_i;
    endcase
  end

  for (genvar i = 0; i < DATA_W; i++) begin : g_wb
    assign wbyte_o[i] = (bit_i == BIT_W'(i)) ? new_bit : data_i[i];
  end

endmodule

// File: rtl/bitcarry_seq.sv
module bitcarry_seq
  import bcs_pkg::*;
#(
  parameter  int DATA_W = 8,
  localparam int BIT_W  = $clog2(DATA_W),
  localparam int ADDR_W = 2 * DATA_W - BIT_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [2:0]        mode_i,
  input  logic              carry_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic [1:0]        bus_op_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic              carry_o,
  output logic              done_o
);

  bit_mode_e         mode;
  seq_st_e           state;
  bus_op_e           op;
  logic              accept, last;
  logic [ADDR_W-1:0] addr;
  logic [BIT_W-1:0]  bit_sel;
  logic [DATA_W-1:0] byte_cur, wbyte;
  logic              carry_q, carry_new, carry_res;

  bcs_ctrl i_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .mode_i   (mode_i),
    .mode_o   (mode),
    .state_o  (state),
    .bus_op_o (op),
    .accept_o (accept),
    .last_o   (last),
    .done_o   (done_o)
  );

  bcs_operand #(.DATA_W(DATA_W)) i_operand (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cap_lo_i   (state == S_FLO),
    .cap_hi_i   (state == S_FHI),
    .cap_data_i (state == S_RD),
    .rdata_i    (rdata_i),
    .addr_o     (addr),
    .bit_o      (bit_sel),
    .data_o     (byte_cur)
  );

  bcs_bitalu #(.DATA_W(DATA_W)) i_alu (
    .mode_i  (mode),
    .bit_i   (bit_sel),
    .data_i  (byte_cur),
    .carry_i (carry_q),
    .carry_o (carry_new),
    .wbyte_o (wbyte)
  );

  assign carry_res = carry_new;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      carry_q <= 1'b0;
      carry_o <= 1'b0;
    end else begin
      if (accept) carry_q <= carry_i;
      if (last)   carry_o <= carry_res;
    end
  end

  assign bus_op_o   = op;
  assign bus_addr_o = (op == BUS_READ || op == BUS_WRITE) ? addr : '0;
  assign wdata_o    = (op == BUS_WRITE) ? wbyte : '0;

  a_r8_single_bit_change: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op == BUS_WRITE |-> $countones(wdata_o ^ byte_cur) <= 1);

  a_r9_carry_moves_with_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(carry_o) |-> done_o);

  a_r6_write_same_address: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op == BUS_WRITE && $past(op) == BUS_READ) |-> bus_addr_o == $past(bus_addr_o));

endmodule

// File: tb/test_bitcarry_seq.sv
module test_bitcarry_seq;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  mode = '0;
  logic        carry_in = 1'b0;
  logic [7:0]  rdata = '0;
  logic [1:0]  bus_op;
  logic [12:0] bus_addr;
  logic [7:0]  wdata;
  logic        carry_out;
  logic        done;

  int n_cmp = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  bitcarry_seq i_bitcarry_seq (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .start_i    (start),
    .mode_i     (mode),
    .carry_i    (carry_in),
    .rdata_i    (rdata),
    .bus_op_o   (bus_op),
    .bus_addr_o (bus_addr),
    .wdata_o    (wdata),
    .carry_o    (carry_out),
    .done_o     (done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic bit ref_carry(int m, bit c, bit b);
    case (m)
      0: return c | b;
      1: return c | ~b;
      2: return c & b;
      3: return c & ~b;
      4: return c ^ b;
      5: return b;
      default: return c;
    endcase
  endfunction

  // one full operation; poke_busy sends a stray start during the run (R10)
  task automatic run_op(input int m, input int bidx, input int addr, input bit c,
                        input logic [7:0] mem, input bit poke_busy);
    int exp_ops[$];
    logic [15:0] word;
    bit b;
    logic [7:0] exp_w;
    word  = {3'(bidx), 13'(addr)};
    b     = mem[bidx];
    exp_w = mem;
    if (m == 6) exp_w[bidx] = c;
    if (m == 7) exp_w[bidx] = ~mem[bidx];
    exp_ops = '{1, 1, 2};
    if (m == 0 || m == 1 || m == 4 || m == 6) exp_ops.push_back(0); // R7 gap
    if (m == 6 || m == 7) exp_ops.push_back(3);
    @(negedge clk);
    start = 1'b1; mode = 3'(m); carry_in = c;
    for (int k = 0; k < exp_ops.size(); k++) begin
      @(negedge clk);
      start = 1'b0;
      if (poke_busy && k == 1) begin start = 1'b1; mode = 3'(7 - m); carry_in = ~c; end
      chk(bus_op == 2'(exp_ops[k]), "R7 R2 bus op sequence", bus_op, exp_ops[k]);
      chk(done == 1'b0, "R9 done low while busy", done, 0);
      case (exp_ops[k])
        1: rdata = (k == 0) ? word[7:0] : word[15:8]; // R1 low byte first
        2: begin
          rdata = mem;
          chk(bus_addr == 13'(addr), "R1 read address", bus_addr, addr);
        end
        3: begin
          rdata = 8'h00;
          chk(bus_addr == 13'(addr), "R6 write address", bus_addr, addr);
          chk(wdata == exp_w, "R6 R8 written byte", wdata, exp_w);
        end
        default: rdata = 8'h00;
      endcase
    end
    @(negedge clk);
    start = 1'b0;
    chk(done == 1'b1, "R9 done pulse", done, 1);
    chk(carry_out == ref_carry(m, c, b),
        (m < 2) ? "R3 carry or" : (m < 4) ? "R4 carry and" : (m < 6) ? "R5 carry xor/load" : "R9 carry kept",
        carry_out, ref_carry(m, c, b));
    chk(bus_op == 2'd0, "R2 idle after op", bus_op, 0);
    @(negedge clk);
    chk(done == 1'b0, "R9 done single cycle", done, 0);
    chk(carry_out == ref_carry(m, c, b), "R9 carry held", carry_out, ref_carry(m, c, b));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(bus_op == 2'd0, "R2 reset bus idle", bus_op, 0);
    chk(done == 1'b0, "R9 reset done low", done, 0);
    chk(carry_out == 1'b0, "R9 reset carry", carry_out, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(bus_op == 2'd0, "R2 idle without start", bus_op, 0);
    for (int m = 0; m < 8; m++) begin
      for (int c = 0; c < 2; c++) begin
        for (int p = 0; p < 4; p++) begin
          run_op(m, (m * 3 + p * 5 + c) % 8, (m * 1031 + p * 977 + c * 4099) % 8192, c[0],
                 8'(8'h5a ^ (p * 8'h33) ^ (m << 4)), 1'b0);
        end
      end
    end
    // boundary: bit 7, top address; bit 0, address 0
    run_op(6, 7, 8191, 1'b1, 8'h00, 1'b0);
    run_op(7, 0, 0, 1'b0, 8'hff, 1'b0);
    run_op(5, 7, 8191, 1'b0, 8'h80, 1'b0);
    // R10: stray start while busy
    run_op(2, 3, 100, 1'b1, 8'h08, 1'b1);
    run_op(7, 4, 200, 1'b0, 8'h00, 1'b1);
    run_op(0, 6, 300, 1'b0, 8'h00, 1'b1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule